// File: doc/BRIEF.md
# Wait and Stop Halt Controller

This block decides when a processor core may advance and how it leaves a halt. The instruction decoder sends a one-cycle wait strobe or stop strobe. The block then drops the core-run enable and holds it low until a legal release event arrives. Run-enable is a synchronous enable. The gating cell that it would drive and the vector fetch that follows a release both sit outside this block.

In the waiting state, any hardware interrupt ends the halt, and this includes a maskable request that the interrupt-disable flag is currently blocking. A blocked request lets the core continue at the instruction after the wait, without vectoring. An unblocked maskable request, a non-maskable request or an abort request hands control to the interrupt entry sequencer instead.

In the stopped state, every interrupt line is ignored. Only the reset input brings the core back, and it restarts through the boot sequence, which fetches the reset vector. The three asynchronous interrupt lines pass through a two-flop synchronizer before the block evaluates them.

Top module: `halt_ctrl`

## Requirements
- R1: While `rst_n` is low, `boot_start` is 1 and `run_en`, `resume_next` and `take_intr` are 0. At the first rising clock edge after `rst_n` goes high, `boot_start` falls to 0 and `run_en` rises to 1.
- R2: While running, a `wait_stb` sampled at a rising edge drives `run_en` to 0 from that edge onward. It stays 0 until a release event occurs.
- R3: While running, a `stop_stb` sampled at a rising edge drives `run_en` to 0 from that edge onward. When `stop_stb` and `wait_stb` are both high in the same cycle, the block enters the stopped state.
- R4: Wake latency from the waiting state is fixed. An interrupt line that goes low before rising edge E1 is captured at E1 and synchronized at E2. At E3, `run_en` returns to 1 and exactly one of the two release pulses is raised.
- R5: If only the maskable line (`irq_n`) is low and `irq_mask` is 1, the block leaves the waiting state. `resume_next` is 1 for exactly one cycle and `take_intr` stays 0.
- R6: In each of these cases, a release from the waiting state raises `take_intr` for exactly one cycle and leaves `resume_next` at 0:
  - `nmi_n` is low;
  - `abort_n` is low;
  - `irq_n` is low and `irq_mask` is 0.
- R7: While waiting with all three interrupt lines high, `run_en` stays 0 and neither release pulse is raised.
- R8: While stopped, the interrupt lines and `irq_mask` have no effect in any combination. `run_en`, `resume_next` and `take_intr` all stay 0.
- R9: Strobes that arrive while the block is halted are ignored. A `stop_stb` during waiting does not prevent a later interrupt release. A `wait_stb` during stopping does not make the block interruptible.
- R10: Asserting `rst_n` low from any state, including stopped, repeats the boot sequence described in R1.
- R11: `resume_next` and `take_intr` are never high together. Each is high for at most one cycle in a row, and only in a cycle in which `run_en` has just returned from a halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset; the only way out of the stopped state |
| wait_stb | input | 1 | Decoder strobe for the wait-for-interrupt instruction |
| stop_stb | input | 1 | Decoder strobe for the stop instruction |
| irq_n | input | 1 | Maskable interrupt request, active low, asynchronous |
| nmi_n | input | 1 | Non-maskable interrupt request, active low, asynchronous |
| abort_n | input | 1 | Abort request, active low, asynchronous |
| irq_mask | input | 1 | Interrupt-disable flag from the status register |
| run_en | output | 1 | Core may advance this cycle |
| resume_next | output | 1 | One-cycle pulse: continue at the instruction after the wait |
| take_intr | output | 1 | One-cycle pulse: start the interrupt entry sequence |
| boot_start | output | 1 | High during reset and the first cycle after it: start from the reset vector |

## Verification
Several properties are checked by assertions on every cycle:
- the two release pulses are mutually exclusive and last one cycle;
- a wait strobe while running always drops `run_en` at the next edge;
- the stopped state persists until reset;
- a synchronized non-maskable request while waiting always produces `take_intr`.

Other behaviour can only be shown by the bench's scenarios, because it depends on particular input histories. This covers the exact three-edge wake latency and the sixteen-way sweep of line and mask combinations with their choice between resuming and vectoring. It also covers the immunity of the stopped state to every combination of lines and mask, the handling of strobes that arrive during a halt, and recovery through reset.

// File: rtl/halt_ctrl_pkg.sv
package halt_ctrl_pkg;

    // Controller states; BOOT is held during reset and for one cycle after it.
    typedef enum logic [1:0] {
        HS_BOOT = 2'd0,
        HS_RUN  = 2'd1,
        HS_WAIT = 2'd2,
        HS_STOP = 2'd3
    } halt_state_e;

    // Bit positions of the interrupt lines inside the synchronized vector.
    localparam int unsigned LINE_CNT = 3;
    localparam int unsigned LN_IRQ   = 0;
    localparam int unsigned LN_NMI   = 1;
    localparam int unsigned LN_ABT   = 2;

    // Registered state of the controller.
    typedef struct packed {
        halt_state_e state;
        logic        resume;
        logic        take;
    } halt_regs_t;

endpackage

// File: rtl/halt_sync.sv
module halt_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        // Shift the raw line in at bit 0; the oldest sample leaves at LAST.
        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign dout[i] = chain_q[LAST];
    end

endmodule

// File: rtl/halt_wake_eval.sv
module halt_wake_eval
    import halt_ctrl_pkg::*;
(
    input  logic [LINE_CNT-1:0] line_act,
    input  logic                irq_mask,
    output logic                wake,
    output logic                go_vector,
    output logic                go_inline
);

    logic hard_src;
    logic irq_open;

    always_comb begin
        // Non-maskable and abort requests always vector.
        hard_src  = line_act[LN_NMI] | line_act[LN_ABT];
        irq_open  = line_act[LN_IRQ] & ~irq_mask;

        wake      = |line_act;
        go_vector = hard_src | irq_open;

        // Only a blocked maskable request resumes without vectoring.
        go_inline = line_act[LN_IRQ] & irq_mask & ~hard_src;
    end

endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl
    import halt_ctrl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_stb,
    input  logic stop_stb,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic abort_n,
    input  logic irq_mask,
    output logic run_en,
    output logic resume_next,
    output logic take_intr,
    output logic boot_start
);

    logic [LINE_CNT-1:0] raw_n;
    logic [LINE_CNT-1:0] sync_n;
    logic [LINE_CNT-1:0] line_act;
    logic                wake;
    logic                go_vector;
    logic                go_inline;
    halt_regs_t          r_d;
    halt_regs_t          r_q;

    // Pack the raw lines so that each one lands at its package bit position.
    always_comb begin
        raw_n         = '1;
        raw_n[LN_IRQ] = irq_n;
        raw_n[LN_NMI] = nmi_n;
        raw_n[LN_ABT] = abort_n;
    end

    halt_sync #(
        .WIDTH   (LINE_CNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_n),
        .dout  (sync_n)
    );

    assign line_act = ~sync_n;

    halt_wake_eval u_eval (
        .line_act  (line_act),
        .irq_mask  (irq_mask),
        .wake      (wake),
        .go_vector (go_vector),
        .go_inline (go_inline)
    );

    // Next-state logic.
    always_comb begin
        r_d        = r_q;
        r_d.resume = 1'b0;
        r_d.take   = 1'b0;

        unique case (r_q.state)
            HS_BOOT: begin
                r_d.state = HS_RUN;
            end
            HS_RUN: begin
                // A stop strobe takes precedence over a wait strobe.
                if (stop_stb) begin
                    r_d.state = HS_STOP;
                end else if (wait_stb) begin
                    r_d.state = HS_WAIT;
                end
            end
            HS_WAIT: begin
                if (wake) begin
                    r_d.state  = HS_RUN;
                    r_d.take   = go_vector;
                    r_d.resume = go_inline;
                end
            end
            HS_STOP: begin
                // Left only through reset.
                r_d.state = HS_STOP;
            end
            default: begin
                r_d.state = HS_BOOT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: HS_BOOT, resume: 1'b0, take: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign run_en      = (r_q.state == HS_RUN);
    assign boot_start  = (r_q.state == HS_BOOT);
    assign resume_next = r_q.resume;
    assign take_intr   = r_q.take;

    // R11
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resume_next && take_intr));

    // R11
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_next || take_intr) |=> !(resume_next || take_intr));

    // R11
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_next || take_intr) |-> (run_en && $past(r_q.state) == HS_WAIT));

    // R2
    wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == HS_RUN && wait_stb) |=> !run_en);

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == HS_STOP) |=> (r_q.state == HS_STOP && !resume_next && !take_intr));

    // R6
    nmi_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == HS_WAIT && !sync_n[LN_NMI]) |=> take_intr);

endmodule

// File: tb/halt_ctrl_bench.sv
`timescale 1ns/1ps
module halt_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n, wait_stb, stop_stb, irq_n, nmi_n, abort_n, irq_mask;
    logic run_en, resume_next, take_intr, boot_start;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #5 clk = ~clk;

    halt_ctrl u_halt_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_stb    (wait_stb),
        .stop_stb    (stop_stb),
        .irq_n       (irq_n),
        .nmi_n       (nmi_n),
        .abort_n     (abort_n),
        .irq_mask    (irq_mask),
        .run_en      (run_en),
        .resume_next (resume_next),
        .take_intr   (take_intr),
        .boot_start  (boot_start)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic lines(input logic i, input logic n, input logic a);
        irq_n = i; nmi_n = n; abort_n = a;
    endtask

    // Reset and boot; each call checks R1 (and R10 when called from a halt).
    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({tag, " boot_start in reset"}, boot_start, 1'b1);
        chk({tag, " run_en in reset"}, run_en, 1'b0);
        chk({tag, " pulses in reset"}, resume_next | take_intr, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({tag, " run_en after boot"}, run_en, 1'b1);
        chk({tag, " boot_start after boot"}, boot_start, 1'b0);
    endtask

    // Present a one-cycle strobe at a negedge; returns at the following negedge.
    task automatic strobe(input logic w, input logic s);
        wait_stb = w; stop_stb = s;
        @(negedge clk);
        wait_stb = 1'b0; stop_stb = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; wait_stb = 0; stop_stb = 0; irq_mask = 0;
        lines(1, 1, 1);
        do_reset("R1");

        // Sweep over every line combination and mask value, starting from waiting.
        for (int combo = 0; combo < 16; combo++) begin
            logic li, ln, la, m, wk, tk, rs;
            string tg;
            li = combo[0]; ln = combo[1]; la = combo[2]; m = combo[3];
            wk = li | ln | la;
            tk = ln | la | (li & ~m);
            rs = li & m & ~ln & ~la;
            tg = wk ? (tk ? "R6" : "R5") : "R7";
            strobe(1'b1, 1'b0);
            chk("R2 run_en low after wait strobe", run_en, 1'b0);
            irq_mask = m;
            lines(~li, ~ln, ~la);
            @(negedge clk);
            chk("R4 still halted after first edge", run_en, 1'b0);
            @(negedge clk);
            chk("R4 still halted after second edge", run_en, 1'b0);
            @(negedge clk);
            chk({tg, " R4 run_en at third edge"}, run_en, wk);
            chk({tg, " take_intr"}, take_intr, tk);
            chk({tg, " resume_next"}, resume_next, rs);
            @(negedge clk);
            chk("R11 pulses last one cycle", resume_next | take_intr, 1'b0);
            chk({tg, " run_en settled"}, run_en, wk);
            lines(1, 1, 1);
            irq_mask = 0;
            if (!wk) do_reset("R10 from wait");
            else begin
                repeat (3) @(negedge clk);
            end
        end

        // Stop state ignores every line and mask combination.
        for (int combo = 0; combo < 16; combo++) begin
            strobe(1'b0, 1'b1);
            chk("R3 run_en low after stop strobe", run_en, 1'b0);
            irq_mask = combo[3];
            lines(~combo[0], ~combo[1], ~combo[2]);
            repeat (5) begin
                @(negedge clk);
                chk("R8 run_en stays low while stopped", run_en, 1'b0);
                chk("R8 no pulse while stopped", resume_next | take_intr, 1'b0);
            end
            lines(1, 1, 1);
            do_reset("R10 from stop");
        end

        // Both strobes together: stop wins.
        strobe(1'b1, 1'b1);
        irq_mask = 0;
        lines(0, 0, 1);
        repeat (5) @(negedge clk);
        chk("R3 both strobes enter stop", run_en, 1'b0);
        lines(1, 1, 1);
        do_reset("R10 after dual strobe");

        // Stop strobe while waiting is ignored.
        strobe(1'b1, 1'b0);
        strobe(1'b0, 1'b1);
        chk("R9 halted after stop strobe in wait", run_en, 1'b0);
        irq_mask = 1;
        lines(0, 1, 1);
        repeat (3) @(negedge clk);
        chk("R9 wait still wakes", run_en, 1'b1);
        chk("R9 masked release resumes", resume_next, 1'b1);
        lines(1, 1, 1);
        repeat (3) @(negedge clk);

        // Wait strobe while stopped is ignored.
        strobe(1'b0, 1'b1);
        strobe(1'b1, 1'b0);
        irq_mask = 0;
        lines(0, 1, 1);
        repeat (5) @(negedge clk);
        chk("R9 stop not made interruptible", run_en, 1'b0);
        chk("R9 no take while stopped", take_intr, 1'b0);
        lines(1, 1, 1);
        do_reset("R10 final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule